// File: doc/BRIEF.md
# Variable-Page Address Translation Buffer

This block maps 32-bit virtual addresses to 32-bit physical addresses through a table of 32 entries that are all searched at once. Each entry holds a virtual base, a physical base, an 8-bit address-space tag, a page-size code, a valid flag and a pin flag. The page-size code picks one of nine page sizes, from 4 KB to 256 MB, in steps of four. A lookup is purely combinational from the presented address and tag. It returns a hit flag, the translated address and the index of the entry that produced it.

Software fills the table through a write port that names the target slot directly. A round-robin victim index is offered as a suggested next slot. Two flush operations are provided: one drops every entry, and one drops the entries whose page covers a given address. Both flushes leave pinned entries in place. A lookup that finds more than one matching entry raises a conflict flag and uses the lowest-numbered match.

Top module: `tlb_core`

## Requirements
- R1: After reset, no entry is valid, no lookup hits, and the victim index is 0.
- R2: Lookup is combinational from `lk_vaddr` and `lk_pid`. A table write becomes visible to lookups only after the next rising clock edge. On a hit, `lk_index` gives the slot of the matching entry.
- R3: With size code c (0..8), the low 12+2c address bits are the page offset. The entry matches when `lk_vaddr` and the stored virtual base agree above the offset. `lk_paddr` is the stored physical base above the offset, joined to `lk_vaddr` below it. Codes 9..15 act as code 8.
- R4: An entry matches only if its stored tag equals `lk_pid` or its stored tag is 0, which marks the entry as global.
- R5: When several entries match, `lk_multi` is 1 and `lk_index`/`lk_paddr` come from the lowest-numbered matching entry.
- R6: On a miss, `lk_hit`, `lk_multi`, `lk_index` and `lk_paddr` are all 0.
- R7: A cycle with `inv_all` high clears every unpinned entry at the next edge. Pinned entries (written with `wr_protect`=1) keep translating.
- R8: A cycle with `inv_addr_en` high clears, at the next edge, every valid unpinned entry whose page covers `inv_vaddr`, whatever its tag. Pinned entries and entries whose page does not cover `inv_vaddr` are kept.
- R9: A write in the same cycle as a flush is applied after the flush, so the written entry is present afterwards.
- R10: `victim` increments by one on every clock edge that carries a write and wraps from 31 to 0. It holds otherwise.
- R11: An entry written with `wr_valid`=0 never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_pid | input | 8 | Current address-space tag |
| lk_hit | output | 1 | A matching entry exists |
| lk_paddr | output | 32 | Translated physical address (0 on miss) |
| lk_index | output | 5 | Slot of the selected entry (0 on miss) |
| lk_multi | output | 1 | More than one entry matched |
| wr_en | input | 1 | Write the slot named by wr_index |
| wr_index | input | 5 | Slot to write |
| wr_vbase | input | 32 | Virtual base (bits below the offset ignored) |
| wr_pbase | input | 32 | Physical base (bits below the offset ignored) |
| wr_pid | input | 8 | Tag for the entry, 0 for global |
| wr_size | input | 4 | Page-size code |
| wr_valid | input | 1 | Valid flag for the entry |
| wr_protect | input | 1 | Pin flag: entry survives flushes |
| inv_all | input | 1 | Flush all unpinned entries |
| inv_addr_en | input | 1 | Flush unpinned entries covering inv_vaddr |
| inv_vaddr | input | 32 | Address for the selective flush |
| victim | output | 5 | Round-robin suggested slot |

## Verification
Some properties are checked on every cycle. A conflict always comes with a hit. A hit always passes the lowest 12 address bits through unchanged. A miss drives index and address to zero. The victim index steps exactly once per write. A valid write is seen by an unchanged lookup one cycle later. The bench scenarios cover the rest: the exact physical address for each page size, the clamping of large codes, global versus tagged matching, lowest-index selection on overlap, and survival of pinned entries across both kinds of flush. They also cover a write that coincides with a flush, and the wrap of the victim index.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int ADDR_W   = 32;
    parameter int PID_W    = 8;
    parameter int SIZE_W   = 4;
    parameter int MAX_CODE = 8;
    parameter int MIN_OFF  = 12;
    parameter int OFF_STEP = 2;

    typedef struct packed {
        logic              valid;
        logic              protect;
        logic [PID_W-1:0]  pid;
        logic [SIZE_W-1:0] size;
        logic [ADDR_W-1:0] vbase;
        logic [ADDR_W-1:0] pbase;
    } tlb_entry_t;

    // Mask of the page-number bits for a size code; codes past the top size clamp.
    function automatic logic [ADDR_W-1:0] page_mask(input logic [SIZE_W-1:0] code);
        int unsigned c;
        c = (int'(code) > MAX_CODE) ? MAX_CODE : int'(code);
        return {ADDR_W{1'b1}} << (MIN_OFF + OFF_STEP * c);
    endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
(
    input  logic              ent_valid,
    input  logic [PID_W-1:0]  ent_pid,
    input  logic [SIZE_W-1:0] ent_size,
    input  logic [ADDR_W-1:0] ent_vbase,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [PID_W-1:0]  pid,
    input  logic              use_pid,
    output logic              match
);
    logic [ADDR_W-1:0] mask;
    logic              pid_ok;

    always_comb begin
        mask   = page_mask(ent_size);
        pid_ok = !use_pid || (ent_pid == pid) || (ent_pid == '0);
        match  = ent_valid && pid_ok && (((ent_vbase ^ vaddr) & mask) == '0);
    end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
    parameter int N     = 32,
    localparam int IW   = $clog2(N)
) (
    input  logic [N-1:0]  hits,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic          multi
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
        multi = ($countones(hits) > 1);
    end
endmodule

// File: rtl/tlb_core.sv
module tlb_core
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_vaddr,
    input  logic [PID_W-1:0]  lk_pid,
    output logic              lk_hit,
    output logic [ADDR_W-1:0] lk_paddr,
    output logic [IDX_W-1:0]  lk_index,
    output logic              lk_multi,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic [ADDR_W-1:0] wr_vbase,
    input  logic [ADDR_W-1:0] wr_pbase,
    input  logic [PID_W-1:0]  wr_pid,
    input  logic [SIZE_W-1:0] wr_size,
    input  logic              wr_valid,
    input  logic              wr_protect,
    input  logic              inv_all,
    input  logic              inv_addr_en,
    input  logic [ADDR_W-1:0] inv_vaddr,
    output logic [IDX_W-1:0]  victim
);
    typedef struct packed {
        tlb_entry_t [ENTRIES-1:0] ent;
        logic [IDX_W-1:0]         victim;
    } state_t;

    state_t st_d, st_q;

    logic [ENTRIES-1:0] lk_hits;
    logic [ENTRIES-1:0] inv_hits;
    logic [IDX_W-1:0]   sel_idx;
    logic               sel_found;
    logic               sel_multi;
    logic [ADDR_W-1:0]  sel_mask;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        tlb_match u_lk (
            .ent_valid (st_q.ent[g].valid),
            .ent_pid   (st_q.ent[g].pid),
            .ent_size  (st_q.ent[g].size),
            .ent_vbase (st_q.ent[g].vbase),
            .vaddr     (lk_vaddr),
            .pid       (lk_pid),
            .use_pid   (1'b1),
            .match     (lk_hits[g])
        );
        tlb_match u_inv (
            .ent_valid (st_q.ent[g].valid),
            .ent_pid   (st_q.ent[g].pid),
            .ent_size  (st_q.ent[g].size),
            .ent_vbase (st_q.ent[g].vbase),
            .vaddr     (inv_vaddr),
            .pid       (lk_pid),
            .use_pid   (1'b0),
            .match     (inv_hits[g])
        );
    end

    tlb_pick #(.N(ENTRIES)) u_pick (
        .hits  (lk_hits),
        .found (sel_found),
        .idx   (sel_idx),
        .multi (sel_multi)
    );

    always_comb begin
        sel_mask = page_mask(st_q.ent[sel_idx].size);
        lk_hit   = sel_found;
        lk_multi = sel_multi;
        lk_index = sel_found ? sel_idx : '0;
        lk_paddr = sel_found ? ((st_q.ent[sel_idx].pbase & sel_mask) | (lk_vaddr & ~sel_mask))
                             : '0;
        victim   = st_q.victim;
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < ENTRIES; i++) begin
            if ((inv_all || (inv_addr_en && inv_hits[i])) && !st_q.ent[i].protect) begin
                st_d.ent[i].valid = 1'b0;
            end
        end
        if (wr_en) begin
            st_d.ent[wr_index].valid   = wr_valid;
            st_d.ent[wr_index].protect = wr_protect;
            st_d.ent[wr_index].pid     = wr_pid;
            st_d.ent[wr_index].size    = wr_size;
            st_d.ent[wr_index].vbase   = wr_vbase;
            st_d.ent[wr_index].pbase   = wr_pbase;
            st_d.victim                = st_q.victim + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tlb_core_chk.sv
module tlb_core_chk
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] lk_vaddr,
    input logic [PID_W-1:0]  lk_pid,
    input logic              lk_hit,
    input logic [ADDR_W-1:0] lk_paddr,
    input logic [IDX_W-1:0]  lk_index,
    input logic              lk_multi,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_vbase,
    input logic [PID_W-1:0]  wr_pid,
    input logic              wr_valid,
    input logic [IDX_W-1:0]  victim
);
    // R5: a conflict is only reported alongside a hit
    a_r5_multi_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        lk_multi |-> lk_hit);

    // R3: the smallest page offset always passes through untranslated
    a_r3_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[MIN_OFF-1:0] == lk_vaddr[MIN_OFF-1:0]));

    // R6: miss outputs are zero
    a_r6_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_paddr == '0 && lk_index == '0 && !lk_multi));

    // R10: victim steps once per write
    a_r10_victim_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (victim == IDX_W'($past(victim) + 1'b1)));
    a_r10_victim_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(victim));

    // R2: a valid write is seen by an unchanged matching lookup one cycle later
    a_r2_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_valid && lk_vaddr == wr_vbase && lk_pid == wr_pid)
        |=> (!($stable(lk_vaddr) && $stable(lk_pid)) || lk_hit));
endmodule

bind tlb_core tlb_core_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_vaddr (lk_vaddr),
    .lk_pid   (lk_pid),
    .lk_hit   (lk_hit),
    .lk_paddr (lk_paddr),
    .lk_index (lk_index),
    .lk_multi (lk_multi),
    .wr_en    (wr_en),
    .wr_vbase (wr_vbase),
    .wr_pid   (wr_pid),
    .wr_valid (wr_valid),
    .victim   (victim)
);

// File: tb/tlb_core_tb.sv
module tlb_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_pid = '0;
    logic        lk_hit;
    logic [31:0] lk_paddr;
    logic [4:0]  lk_index;
    logic        lk_multi;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_index = '0;
    logic [31:0] wr_vbase = '0;
    logic [31:0] wr_pbase = '0;
    logic [7:0]  wr_pid = '0;
    logic [3:0]  wr_size = '0;
    logic        wr_valid = 1'b0;
    logic        wr_protect = 1'b0;
    logic        inv_all = 1'b0;
    logic        inv_addr_en = 1'b0;
    logic [31:0] inv_vaddr = '0;
    logic [4:0]  victim;

    int checks = 0;
    int fails = 0;
    int wcount = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tlb_core u_dut (
        .clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_pid(lk_pid),
        .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_index(lk_index), .lk_multi(lk_multi),
        .wr_en(wr_en), .wr_index(wr_index), .wr_vbase(wr_vbase), .wr_pbase(wr_pbase),
        .wr_pid(wr_pid), .wr_size(wr_size), .wr_valid(wr_valid), .wr_protect(wr_protect),
        .inv_all(inv_all), .inv_addr_en(inv_addr_en), .inv_vaddr(inv_vaddr), .victim(victim)
    );

    typedef struct packed {
        logic [31:0] va;
        logic [7:0]  pid;
        logic        hit;
        logic [4:0]  idx;
        logic [31:0] pa;
        logic        multi;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VEC [NVEC] = '{
        '{32'h0000_1ABC, 8'd5, 1'b1, 5'd0,  32'h8000_0ABC, 1'b0, 8'd3},  // R3 4 KB
        '{32'h0000_1ABC, 8'd6, 1'b0, 5'd0,  32'h0000_0000, 1'b0, 8'd4},  // R4 tag mismatch
        '{32'h1234_9999, 8'd7, 1'b1, 5'd1,  32'hABCD_9999, 1'b0, 8'd4},  // R4 global entry
        '{32'h3FFF_FFF0, 8'd3, 1'b1, 5'd2,  32'h5FFF_FFF0, 1'b0, 8'd3},  // R3 256 MB
        '{32'h7123_4567, 8'd3, 1'b1, 5'd3,  32'h1123_4567, 1'b0, 8'd3},  // R3 code clamp
        '{32'h0000_7FFE, 8'd9, 1'b1, 5'd4,  32'h2222_FFFE, 1'b0, 8'd3},  // R3 16 KB
        '{32'h0000_8000, 8'd9, 1'b0, 5'd0,  32'h0000_0000, 1'b0, 8'd6},  // R6 just past page
        '{32'h6000_0123, 8'd4, 1'b1, 5'd6,  32'h0AAA_A123, 1'b1, 8'd5},  // R5 overlap
        '{32'h6000_2123, 8'd4, 1'b1, 5'd10, 32'h0BB0_2123, 1'b0, 8'd5},  // R5 single in big page
        '{32'h9000_0000, 8'd1, 1'b0, 5'd0,  32'h0000_0000, 1'b0, 8'd11}, // R11 invalid entry
        '{32'hE000_0000, 8'd0, 1'b0, 5'd0,  32'h0000_0000, 1'b0, 8'd6}   // R6 empty region
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] idx, input logic [31:0] vb, input logic [31:0] pb,
                      input logic [7:0] pid, input logic [3:0] sz, input logic v, input logic p);
        @(negedge clk);
        wr_en = 1'b1; wr_index = idx; wr_vbase = vb; wr_pbase = pb;
        wr_pid = pid; wr_size = sz; wr_valid = v; wr_protect = p;
        @(negedge clk);
        wr_en = 1'b0;
        wcount++;
    endtask

    task automatic lk(input logic [31:0] va, input logic [7:0] pid, input logic eh,
                      input logic [4:0] ei, input logic [31:0] ep, input logic em, input string req);
        @(negedge clk);
        lk_vaddr = va; lk_pid = pid;
        #2;
        chk(lk_hit == eh, {req, " hit"}, 32'(lk_hit), 32'(eh));
        if (eh) begin
            chk(lk_index == ei, {req, " index"}, 32'(lk_index), 32'(ei));
            chk(lk_paddr == ep, {req, " paddr"}, lk_paddr, ep);
            chk(lk_multi == em, {req, " multi"}, 32'(lk_multi), 32'(em));
        end else begin
            chk(lk_paddr == 0 && lk_index == 0 && !lk_multi, {req, " miss outputs"},
                lk_paddr, 32'h0);
        end
    endtask

    task automatic pulse_inv(input bit all, input logic [31:0] va);
        @(negedge clk);
        inv_all = all; inv_addr_en = !all; inv_vaddr = va;
        @(negedge clk);
        inv_all = 1'b0; inv_addr_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 / R6: empty table after reset
        lk(32'h0000_1ABC, 8'd5, 1'b0, 5'd0, 32'h0, 1'b0, "R1");
        chk(victim == 0, "R1 victim", 32'(victim), 32'h0);

        // R2: write is not visible before the edge, visible after
        @(negedge clk);
        lk_vaddr = 32'h0000_1ABC; lk_pid = 8'd5;
        wr_en = 1'b1; wr_index = 5'd0; wr_vbase = 32'h0000_1000; wr_pbase = 32'h8000_0000;
        wr_pid = 8'd5; wr_size = 4'd0; wr_valid = 1'b1; wr_protect = 1'b0;
        #2;
        chk(!lk_hit, "R2 before edge", 32'(lk_hit), 32'h0);
        @(negedge clk);
        wr_en = 1'b0; wcount++;
        #2;
        chk(lk_hit && lk_index == 0, "R2 after edge", 32'(lk_index), 32'h0);

        wr(5'd1,  32'h1234_5678, 32'hABCD_0000, 8'd0, 4'd2,  1'b1, 1'b1);
        wr(5'd2,  32'h3000_0000, 32'h5000_0000, 8'd3, 4'd8,  1'b1, 1'b1);
        wr(5'd3,  32'h7000_0000, 32'h1000_0000, 8'd3, 4'd15, 1'b1, 1'b0);
        wr(5'd4,  32'h0000_4000, 32'h2222_C000, 8'd9, 4'd1,  1'b1, 1'b0);
        wr(5'd5,  32'h9000_0000, 32'h4444_0000, 8'd1, 4'd0,  1'b0, 1'b0);
        wr(5'd6,  32'h6000_0000, 32'h0AAA_A000, 8'd4, 4'd0,  1'b1, 1'b0);
        wr(5'd10, 32'h6000_0000, 32'h0BB0_0000, 8'd4, 4'd3,  1'b1, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            lk(VEC[i].va, VEC[i].pid, VEC[i].hit, VEC[i].idx, VEC[i].pa, VEC[i].multi,
               $sformatf("R%0d vec%0d", VEC[i].req, i));
        end

        chk(victim == 5'(wcount), "R10 count", 32'(victim), 32'(wcount));

        // R7: flush all keeps pinned entries 1 and 2
        pulse_inv(1'b1, 32'h0);
        lk(32'h0000_1ABC, 8'd5, 1'b0, 5'd0, 32'h0, 1'b0, "R7 unpinned gone");
        lk(32'h6000_0123, 8'd4, 1'b0, 5'd0, 32'h0, 1'b0, "R7 overlap gone");
        lk(32'h1234_0001, 8'd2, 1'b1, 5'd1, 32'hABCD_0001, 1'b0, "R7 pinned kept");
        lk(32'h3000_0040, 8'd3, 1'b1, 5'd2, 32'h5000_0040, 1'b0, "R7 pinned kept 2");

        // R8: flush by address
        wr(5'd4, 32'h0000_4000, 32'h2222_C000, 8'd9, 4'd1, 1'b1, 1'b0);
        wr(5'd6, 32'h6000_0000, 32'h0AAA_A000, 8'd4, 4'd0, 1'b1, 1'b0);
        pulse_inv(1'b0, 32'h0000_5000);
        lk(32'h0000_4010, 8'd9, 1'b0, 5'd0, 32'h0, 1'b0, "R8 covered gone");
        lk(32'h6000_0010, 8'd4, 1'b1, 5'd6, 32'h0AAA_A010, 1'b0, "R8 other kept");
        pulse_inv(1'b0, 32'h1234_0000);
        lk(32'h1234_0002, 8'd7, 1'b1, 5'd1, 32'hABCD_0002, 1'b0, "R8 pinned kept");

        // R9: write together with a flush-all
        @(negedge clk);
        inv_all = 1'b1;
        wr_en = 1'b1; wr_index = 5'd7; wr_vbase = 32'hC000_0000; wr_pbase = 32'h0000_5000;
        wr_pid = 8'd2; wr_size = 4'd0; wr_valid = 1'b1; wr_protect = 1'b0;
        @(negedge clk);
        inv_all = 1'b0; wr_en = 1'b0; wcount++;
        lk(32'hC000_0010, 8'd2, 1'b1, 5'd7, 32'h0000_5010, 1'b0, "R9");
        lk(32'h6000_0010, 8'd4, 1'b0, 5'd0, 32'h0, 1'b0, "R9 flush still done");

        // R10: wrap of the victim index
        for (int i = 0; i < 40; i++) begin
            wr(5'd31, 32'hF000_0000, 32'h0, 8'd0, 4'd0, 1'b0, 1'b0);
            if (wcount % 32 == 0)
                chk(victim == 0, "R10 wrap", 32'(victim), 32'h0);
        end
        chk(victim == 5'(wcount), "R10 final", 32'(victim), 32'(wcount % 32));

        // R1: reset again clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        lk(32'h1234_0002, 8'd7, 1'b0, 5'd0, 32'h0, 1'b0, "R1 after reset");
        chk(victim == 0, "R1 victim reset", 32'(victim), 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule